// File: doc/BRIEF.md
# AEGIS-128 Authenticated Stream Cipher Core

This block holds the five-word, 640-bit state of the AEGIS-128 authenticated cipher and advances it by one full state update per clock. A session opens with a key and a nonce. The core loads the state from them and two fixed 128-bit constants, then runs ten warm-up updates on its own. It then takes 16-byte associated-data blocks, which are only absorbed into the state, and 16-byte message blocks. Each message block is encrypted or decrypted, the result leaves on a registered output port, and the plaintext is absorbed.

Each input channel has a valid/ready pair. The output has no backpressure: a result is presented for exactly one cycle, in the cycle after its block is accepted. A message block may be short, from 1 to 15 bytes. A short block closes the session, and only a new key/nonce load reopens it. Producing the tag is left to logic outside this block, which works from the state once the last block has been absorbed.

Top module: `ae128_core`

## Requirements
- R1: After reset, `init_ready` is 1, `ad_ready` and `msg_ready` are 0, and `out_valid` and `init_done` are 0.
- R2: An accepted key/nonce load sets the state words as follows, with word index 0 to 4. Word 0 is K⊕N, word 1 is B, word 2 is A, word 3 is K⊕A, word 4 is K⊕B. A holds the bytes 00 01 01 02 03 05 08 0d 15 22 37 59 90 e9 79 62 and B holds the bytes db 3d 18 55 6d c2 2f f1 20 11 31 42 73 b5 28 dd, in both cases with the first byte in bits 7:0. Ten updates then follow on consecutive cycles, injecting K on the first, K⊕N on the second, and alternating from there. During these ten cycles all three ready outputs are 0.
- R3: `init_done` is high for exactly one cycle, the cycle after the tenth warm-up update. From that cycle on, the block accepts associated data and message blocks.
- R4: An update forms each new word i as R(old word i−1) XOR old word i, where word 0 takes old word 4 as its predecessor. The injected block is then XORed into new word 0. R applies byte substitution, row shifting and column mixing as in one AES round. In R, byte k of a word (bits 8k+7:8k) sits at column k/4, row k%4.
- R5: An accepted associated-data block causes exactly one update, with that block injected, and produces no output.
- R6: In the cycle after a message block is accepted, `out_valid` is 1 for that one cycle. `out_data` then equals the masked input XOR word 1 XOR word 4 XOR (word 2 AND word 3), all taken from the state before that block's update.
- R7: When `msg_decrypt` is 0 the input (plaintext) is injected. When it is 1 the recovered plaintext is injected, so decrypting a ciphertext under the same key, nonce and associated data returns the plaintext.
- R8: `msg_tail` of 0 means a full 16-byte block. A value n from 1 to 15 means only bytes 0..n−1 are used. Input bytes n..15 are treated as zero. `out_mask` has bits 0..n−1 set, and `out_data` bytes n..15 are zero. In decryption, the injected plaintext bytes n..15 are zero.
- R9: After a short message block is accepted, `ad_ready` and `msg_ready` stay 0 until a new key/nonce load completes. `init_ready` stays 1.
- R10: Priority order is key/nonce load first, then associated data, then message. `ad_ready` is 0 while `init_valid` is 1. `msg_ready` is 0 while `init_valid` or `ad_valid` is 1. At most one channel is accepted per cycle.
- R11: A block presented without the matching ready changes neither the state nor the outputs. It is observed through the later output values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, already synchronised on release |
| init_valid | input | 1 | Key/nonce load request |
| init_ready | output | 1 | Key/nonce load can be taken |
| init_key | input | 128 | Key, byte 0 in bits 7:0 |
| init_nonce | input | 128 | Nonce, byte 0 in bits 7:0 |
| ad_valid | input | 1 | Associated-data block present |
| ad_ready | output | 1 | Associated-data block can be taken |
| ad_data | input | 128 | Associated-data block |
| msg_valid | input | 1 | Message block present |
| msg_ready | output | 1 | Message block can be taken |
| msg_data | input | 128 | Plaintext or ciphertext block |
| msg_tail | input | 4 | 0 for a full block, else number of valid bytes |
| msg_decrypt | input | 1 | 1 selects decryption, 0 encryption |
| out_valid | output | 1 | Result present for one cycle |
| out_data | output | 128 | Ciphertext or recovered plaintext, unused bytes zero |
| out_mask | output | 16 | One bit per valid output byte |
| init_done | output | 1 | One-cycle pulse when warm-up ends |

## Verification
The assertions cover the handshake and framing rules, which are visible on every cycle. They check that at most one channel is accepted per cycle and that a key/nonce load drops `init_ready` the next cycle. They check that `init_done` is a single-cycle pulse and that every output follows exactly one accepted message block and none follows an associated-data block. They also check that the output mask is a contiguous low run with zero bytes above it, and that a short block closes the session. The cipher values themselves cannot be checked by a local property: the constants, the warm-up injection order, the round function, the word rotation and the choice of injected plaintext only show through the bench. The bench runs a behavioural model alongside the design and compares every cycle, and it decrypts recorded ciphertexts to recover the plaintext.

// File: rtl/ae128_pkg.sv
package ae128_pkg;

  localparam int unsigned WBITS       = 128;
  localparam int unsigned NWORDS      = 5;
  localparam int unsigned NBYTES      = WBITS / 8;
  localparam int unsigned TAILW       = $clog2(NBYTES);
  localparam int unsigned INIT_ROUNDS = 10;
  localparam int unsigned CNTW        = $clog2(INIT_ROUNDS);

  typedef logic [WBITS-1:0]              word_t;
  typedef logic [NWORDS-1:0][WBITS-1:0]  state_t;
  typedef logic [NBYTES-1:0]             bmask_t;

  typedef enum logic [1:0] {
    PH_COLD   = 2'd0,
    PH_INIT   = 2'd1,
    PH_RUN    = 2'd2,
    PH_SEALED = 2'd3
  } phase_e;

  // Fixed seed words, first byte in bits 7:0
  localparam word_t SEED_A = 128'h6279e990_59372215_0d080503_02010100;
  localparam word_t SEED_B = 128'hdd28b573_42311120_f12fc26d_55183ddb;

  function automatic logic [7:0] gf_x2(input logic [7:0] a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] p;
    logic [7:0] s;
    p = 8'h00;
    s = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) p = p ^ s;
      s = gf_x2(s);
    end
    return p;
  endfunction

  // Substitution: inverse as x^254 (zero maps to zero), then the affine map
  function automatic logic [7:0] sub_byte(input logic [7:0] x);
    logic [7:0] sq;
    logic [7:0] inv;
    sq  = x;
    inv = 8'h01;
    for (int k = 1; k < 8; k++) begin
      sq  = gf_mul(sq, sq);
      inv = gf_mul(inv, sq);
    end
    return inv ^ {inv[6:0], inv[7]} ^ {inv[5:0], inv[7:6]} ^
           {inv[4:0], inv[7:5]} ^ {inv[3:0], inv[7:4]} ^ 8'h63;
  endfunction

  function automatic bmask_t tail_mask(input logic [TAILW-1:0] tail);
    if (tail == '0) return '1;
    return (NBYTES'(1) << tail) - NBYTES'(1);
  endfunction

  function automatic word_t widen_mask(input bmask_t m);
    word_t w;
    for (int b = 0; b < int'(NBYTES); b++) w[8*b +: 8] = {8{m[b]}};
    return w;
  endfunction

endpackage

// File: rtl/ae128_round.sv
module ae128_round
  import ae128_pkg::*;
(
  input  word_t din,
  input  word_t rk,
  output word_t dout
);

  function automatic word_t one_round(input word_t x, input word_t k);
    word_t      y;
    logic [7:0] t [4];
    for (int c = 0; c < 4; c++) begin
      for (int r = 0; r < 4; r++) begin
        t[r] = sub_byte(x[8*(4*((c + r) % 4) + r) +: 8]);
      end
      y[8*(4*c+0) +: 8] = gf_x2(t[0]) ^ gf_x2(t[1]) ^ t[1] ^ t[2] ^ t[3];
      y[8*(4*c+1) +: 8] = t[0] ^ gf_x2(t[1]) ^ gf_x2(t[2]) ^ t[2] ^ t[3];
      y[8*(4*c+2) +: 8] = t[0] ^ t[1] ^ gf_x2(t[2]) ^ gf_x2(t[3]) ^ t[3];
      y[8*(4*c+3) +: 8] = gf_x2(t[0]) ^ t[0] ^ t[1] ^ t[2] ^ gf_x2(t[3]);
    end
    return y ^ k;
  endfunction

  assign dout = one_round(din, rk);

endmodule

// File: rtl/ae128_update.sv
module ae128_update
  import ae128_pkg::*;
(
  input  state_t cur,
  input  word_t  inj,
  output state_t nxt
);

  state_t rnd;

  for (genvar i = 0; i < NWORDS; i++) begin : g_word
    ae128_round u_rnd (
      .din  (cur[(i + NWORDS - 1) % NWORDS]),
      .rk   (cur[i]),
      .dout (rnd[i])
    );
    if (i == 0) begin : g_inj
      assign nxt[i] = rnd[i] ^ inj;
    end else begin : g_pass
      assign nxt[i] = rnd[i];
    end
  end

endmodule

// File: rtl/ae128_core.sv
module ae128_core
  import ae128_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        init_valid,
  output logic        init_ready,
  input  logic [127:0] init_key,
  input  logic [127:0] init_nonce,
  input  logic        ad_valid,
  output logic        ad_ready,
  input  logic [127:0] ad_data,
  input  logic        msg_valid,
  output logic        msg_ready,
  input  logic [127:0] msg_data,
  input  logic [3:0]  msg_tail,
  input  logic        msg_decrypt,
  output logic        out_valid,
  output logic [127:0] out_data,
  output logic [15:0] out_mask,
  output logic        init_done
);

  phase_e          phase_q, phase_d;
  logic [CNTW-1:0] cnt_q, cnt_d;
  state_t          st_q, st_d, st_upd, st_load;
  logic            st_en;
  word_t           key_q, kn_q;
  word_t           upd_inj, ks, m_in, m_out, m_inj, m_wide;
  bmask_t          m_bytes;
  logic            acc_init, acc_ad, acc_msg;
  logic            done_d, done_q, ov_d, ov_q;
  word_t           od_q;
  bmask_t          om_q;

  // Handshake: load beats associated data, which beats message
  assign init_ready = (phase_q != PH_INIT);
  assign ad_ready   = (phase_q == PH_RUN) && !init_valid;
  assign msg_ready  = (phase_q == PH_RUN) && !init_valid && !ad_valid;

  assign acc_init = init_valid && init_ready;
  assign acc_ad   = ad_valid && ad_ready;
  assign acc_msg  = msg_valid && msg_ready;

  // Message datapath, taken from the state before the update
  assign m_bytes = tail_mask(msg_tail);
  assign m_wide  = widen_mask(m_bytes);
  assign m_in    = msg_data & m_wide;
  assign ks      = st_q[1] ^ st_q[4] ^ (st_q[2] & st_q[3]);
  assign m_out   = (m_in ^ ks) & m_wide;
  assign m_inj   = msg_decrypt ? m_out : m_in;

  assign st_load[0] = init_key ^ init_nonce;
  assign st_load[1] = SEED_B;
  assign st_load[2] = SEED_A;
  assign st_load[3] = init_key ^ SEED_A;
  assign st_load[4] = init_key ^ SEED_B;

  ae128_update u_upd (
    .cur (st_q),
    .inj (upd_inj),
    .nxt (st_upd)
  );

  // Next-state logic
  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    st_en   = 1'b0;
    st_d    = st_upd;
    upd_inj = '0;
    done_d  = 1'b0;
    ov_d    = 1'b0;
    if (acc_init) begin
      phase_d = PH_INIT;
      cnt_d   = '0;
      st_en   = 1'b1;
      st_d    = st_load;
    end else begin
      unique case (phase_q)
        PH_INIT: begin
          upd_inj = cnt_q[0] ? kn_q : key_q;
          st_en   = 1'b1;
          if (cnt_q == CNTW'(INIT_ROUNDS - 1)) begin
            phase_d = PH_RUN;
            done_d  = 1'b1;
          end else begin
            cnt_d = cnt_q + CNTW'(1);
          end
        end
        PH_RUN: begin
          if (acc_ad) begin
            upd_inj = ad_data;
            st_en   = 1'b1;
          end else if (acc_msg) begin
            upd_inj = m_inj;
            st_en   = 1'b1;
            ov_d    = 1'b1;
            if (msg_tail != '0) phase_d = PH_SEALED;
          end
        end
        default: ;
      endcase
    end
  end

  // Control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_COLD;
      cnt_q   <= '0;
      done_q  <= 1'b0;
      ov_q    <= 1'b0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      done_q  <= done_d;
      ov_q    <= ov_d;
    end
  end

  // Datapath registers, enable only
  always_ff @(posedge clk) begin
    if (st_en) st_q <= st_d;
    if (acc_init) begin
      key_q <= init_key;
      kn_q  <= init_key ^ init_nonce;
    end
    if (acc_msg) begin
      od_q <= m_out;
      om_q <= m_bytes;
    end
  end

  assign out_valid = ov_q;
  assign out_data  = od_q;
  assign out_mask  = om_q;
  assign init_done = done_q;

endmodule

// File: rtl/ae128_core_chk.sv
module ae128_core_chk
  import ae128_pkg::*;
(
  input logic         clk,
  input logic         rst_n,
  input logic         init_valid,
  input logic         init_ready,
  input logic         ad_valid,
  input logic         ad_ready,
  input logic         msg_valid,
  input logic         msg_ready,
  input logic [3:0]   msg_tail,
  input logic         out_valid,
  input logic [127:0] out_data,
  input logic [15:0]  out_mask,
  input logic         init_done
);

  assert_one_accept_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({init_valid && init_ready, ad_valid && ad_ready, msg_valid && msg_ready}) <= 1);

  assert_load_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (init_valid && init_ready) |=> (!init_ready && !ad_ready && !msg_ready));

  assert_done_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> !init_done);

  assert_done_open_R3: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |-> (ad_ready || init_valid));

  assert_no_out_ad_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ad_valid && ad_ready) |=> !out_valid);

  assert_out_follows_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && msg_ready) |=> out_valid);

  assert_out_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(msg_valid && msg_ready));

  assert_mask_shape_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_mask != '0 && ((out_mask + 16'd1) & out_mask) == '0));

  assert_zero_above_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((out_data & ~widen_mask(out_mask)) == '0));

  assert_sealed_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && msg_ready && msg_tail != 4'd0) |=> (!ad_ready && !msg_ready && init_ready));

endmodule

bind ae128_core ae128_core_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .init_valid (init_valid),
  .init_ready (init_ready),
  .ad_valid   (ad_valid),
  .ad_ready   (ad_ready),
  .msg_valid  (msg_valid),
  .msg_ready  (msg_ready),
  .msg_tail   (msg_tail),
  .out_valid  (out_valid),
  .out_data   (out_data),
  .out_mask   (out_mask),
  .init_done  (init_done)
);

// File: tb/test_ae128_core.sv
module test_ae128_core;

  logic         clk;
  logic         rst_n;
  logic         init_valid;
  logic         init_ready;
  logic [127:0] init_key;
  logic [127:0] init_nonce;
  logic         ad_valid;
  logic         ad_ready;
  logic [127:0] ad_data;
  logic         msg_valid;
  logic         msg_ready;
  logic [127:0] msg_data;
  logic [3:0]   msg_tail;
  logic         msg_decrypt;
  logic         out_valid;
  logic [127:0] out_data;
  logic [15:0]  out_mask;
  logic         init_done;

  ae128_core i_ae128_core (
    .clk, .rst_n, .init_valid, .init_ready, .init_key, .init_nonce,
    .ad_valid, .ad_ready, .ad_data, .msg_valid, .msg_ready, .msg_data,
    .msg_tail, .msg_decrypt, .out_valid, .out_data, .out_mask, .init_done
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int    n_chk = 0;
  int    n_bad = 0;
  bit    finished = 0;
  string ctx = "R6";

  // Reference model state
  logic [7:0]   sb [256];
  logic [127:0] mw [5];
  logic [127:0] mk, mkn;
  int           mph = 0;   // 0 cold, 1 warm-up, 2 open, 3 closed
  int           mcnt = 0;
  logic [127:0] e_od, last_out;
  logic [15:0]  e_om;
  logic         e_ov, e_done;

  task automatic chk(string tag, string what, logic [127:0] act, logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [7:0] bmul(logic [7:0] a, logic [7:0] b);
    logic [15:0] p = '0;
    for (int i = 0; i < 8; i++) if (b[i]) p = p ^ (16'(a) << i);
    for (int i = 15; i >= 8; i--) if (p[i]) p = p ^ (16'h011b << (i - 8));
    return p[7:0];
  endfunction

  function automatic logic [7:0] m2(logic [7:0] a);
    return bmul(a, 8'h02);
  endfunction

  function automatic logic [127:0] ref_round(logic [127:0] x, logic [127:0] rk);
    logic [127:0] y;
    logic [7:0] a0, a1, a2, a3;
    for (int c = 0; c < 4; c++) begin
      a0 = sb[x[8*(4*c)            +: 8]];
      a1 = sb[x[8*(4*((c+1)%4)+1)  +: 8]];
      a2 = sb[x[8*(4*((c+2)%4)+2)  +: 8]];
      a3 = sb[x[8*(4*((c+3)%4)+3)  +: 8]];
      y[8*(4*c)   +: 8] = m2(a0) ^ bmul(a1, 8'h03) ^ a2 ^ a3;
      y[8*(4*c+1) +: 8] = a0 ^ m2(a1) ^ bmul(a2, 8'h03) ^ a3;
      y[8*(4*c+2) +: 8] = a0 ^ a1 ^ m2(a2) ^ bmul(a3, 8'h03);
      y[8*(4*c+3) +: 8] = bmul(a0, 8'h03) ^ a1 ^ a2 ^ m2(a3);
    end
    return y ^ rk;
  endfunction

  task automatic model_update(logic [127:0] inj);
    logic [127:0] t [5];
    for (int i = 0; i < 5; i++) t[i] = ref_round(mw[(i + 4) % 5], mw[i]);
    t[0] = t[0] ^ inj;
    for (int i = 0; i < 5; i++) mw[i] = t[i];
  endtask

  function automatic logic [127:0] pack16(logic [7:0] b [16]);
    logic [127:0] w;
    for (int i = 0; i < 16; i++) w[8*i +: 8] = b[i];
    return w;
  endfunction

  // One clock: compare readies, advance model, compare registered outputs
  task automatic cycle();
    logic ri, ra, rm;
    logic [127:0] ca, cb, m, o;
    logic [7:0] a_b [16];
    logic [7:0] b_b [16];
    int n;
    #1;
    ri = (mph != 1);
    ra = (mph == 2) && !init_valid;
    rm = (mph == 2) && !init_valid && !ad_valid;
    chk("R10", "init_ready", 128'(init_ready), 128'(ri));
    chk("R10", "ad_ready",   128'(ad_ready),   128'(ra));
    chk("R10", "msg_ready",  128'(msg_ready),  128'(rm));
    e_ov = 1'b0;
    e_done = 1'b0;
    if (init_valid && ri) begin
      a_b = '{8'h00,8'h01,8'h01,8'h02,8'h03,8'h05,8'h08,8'h0d,
              8'h15,8'h22,8'h37,8'h59,8'h90,8'he9,8'h79,8'h62};
      b_b = '{8'hdb,8'h3d,8'h18,8'h55,8'h6d,8'hc2,8'h2f,8'hf1,
              8'h20,8'h11,8'h31,8'h42,8'h73,8'hb5,8'h28,8'hdd};
      ca = pack16(a_b);
      cb = pack16(b_b);
      mw[0] = init_key ^ init_nonce;
      mw[1] = cb;
      mw[2] = ca;
      mw[3] = init_key ^ ca;
      mw[4] = init_key ^ cb;
      mk = init_key;
      mkn = init_key ^ init_nonce;
      mph = 1;
      mcnt = 0;
    end else if (mph == 1) begin
      model_update((mcnt % 2 == 1) ? mkn : mk);
      if (mcnt == 9) begin
        mph = 2;
        e_done = 1'b1;
      end else mcnt++;
    end else if (mph == 2 && ad_valid && ra) begin
      model_update(ad_data);
    end else if (mph == 2 && msg_valid && rm) begin
      n = (msg_tail == 0) ? 16 : int'(msg_tail);
      m = '0;
      for (int i = 0; i < n; i++) m[8*i +: 8] = msg_data[8*i +: 8];
      o = m ^ mw[1] ^ mw[4] ^ (mw[2] & mw[3]);
      for (int i = n; i < 16; i++) o[8*i +: 8] = 8'h00;
      e_od = o;
      e_om = '0;
      for (int i = 0; i < n; i++) e_om[i] = 1'b1;
      e_ov = 1'b1;
      model_update(msg_decrypt ? o : m);
      if (msg_tail != 0) mph = 3;
    end
    @(posedge clk);
    @(negedge clk);
    chk(ctx, "out_valid", 128'(out_valid), 128'(e_ov));
    chk("R3", "init_done", 128'(init_done), 128'(e_done));
    if (e_ov) begin
      chk(ctx, "out_data", out_data, e_od);
      chk("R8", "out_mask", 128'(out_mask), 128'(e_om));
      last_out = out_data;
    end
  endtask

  task automatic quiet();
    init_valid = 0; ad_valid = 0; msg_valid = 0;
  endtask

  task automatic do_init(logic [127:0] k, logic [127:0] n);
    quiet();
    init_valid = 1; init_key = k; init_nonce = n;
    cycle();
    init_valid = 0;
    for (int i = 0; i < 10; i++) cycle();
  endtask

  task automatic do_ad(logic [127:0] d);
    quiet();
    ad_valid = 1; ad_data = d;
    cycle();
    ad_valid = 0;
  endtask

  task automatic do_msg(logic [127:0] d, logic [3:0] tail, logic dec);
    quiet();
    msg_valid = 1; msg_data = d; msg_tail = tail; msg_decrypt = dec;
    cycle();
    msg_valid = 0;
  endtask

  function automatic logic [127:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  // Watchdog
  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [127:0] key1, non1, ad1;
    logic [127:0] pt [4];
    logic [127:0] ct [4];
    logic [127:0] lo5;

    // Reference S-box by search for the inverse and a bitwise affine map
    for (int x = 0; x < 256; x++) begin
      logic [7:0] inv, s;
      inv = 8'h00;
      for (int y = 1; y < 256; y++) if (bmul(8'(x), 8'(y)) == 8'h01) inv = 8'(y);
      for (int i = 0; i < 8; i++)
        s[i] = inv[i] ^ inv[(i+4)%8] ^ inv[(i+5)%8] ^ inv[(i+6)%8] ^ inv[(i+7)%8] ^ ((8'h63 >> i) & 1);
      sb[x] = s;
    end

    rst_n = 0;
    quiet();
    init_key = '0; init_nonce = '0; ad_data = '0; msg_data = '0;
    msg_tail = '0; msg_decrypt = 0;
    repeat (3) @(negedge clk);
    chk("R1", "init_ready", 128'(init_ready), 128'd1);
    chk("R1", "ad_ready",   128'(ad_ready),   128'd0);
    chk("R1", "msg_ready",  128'(msg_ready),  128'd0);
    chk("R1", "out_valid",  128'(out_valid),  128'd0);
    chk("R1", "init_done",  128'(init_done),  128'd0);
    rst_n = 1;

    // Blocks offered before any key are ignored
    ctx = "R11";
    ad_valid = 1; ad_data = rnd128(); msg_valid = 1; msg_data = rnd128();
    cycle(); cycle();
    quiet();

    // Load with blocks offered during warm-up
    ctx = "R2";
    key1 = rnd128(); non1 = rnd128(); ad1 = rnd128();
    init_valid = 1; init_key = key1; init_nonce = non1;
    cycle();
    init_valid = 0; ad_valid = 1; ad_data = rnd128(); msg_valid = 1; msg_data = rnd128();
    for (int i = 0; i < 10; i++) cycle();
    quiet();

    // Associated data, with a message offered alongside (priority)
    ctx = "R5";
    ad_valid = 1; ad_data = ad1; msg_valid = 1; msg_data = rnd128(); msg_tail = 0;
    cycle();
    quiet();

    // Encrypt three full blocks and one 5-byte tail
    ctx = "R6";
    for (int i = 0; i < 3; i++) begin
      pt[i] = rnd128();
      do_msg(pt[i], 4'd0, 1'b0);
      ct[i] = last_out;
    end
    ctx = "R8";
    pt[3] = rnd128();
    do_msg(pt[3], 4'd5, 1'b0);
    ct[3] = last_out;

    // Session closed
    ctx = "R9";
    ad_valid = 1; ad_data = rnd128();
    cycle();
    quiet();
    msg_valid = 1; msg_data = rnd128(); msg_tail = 0;
    cycle();
    quiet();

    // Decrypt under the same key, nonce and associated data
    ctx = "R7";
    do_init(key1, non1);
    do_ad(ad1);
    for (int i = 0; i < 3; i++) begin
      do_msg(ct[i], 4'd0, 1'b1);
      chk("R7", "recovered plaintext", last_out, pt[i]);
    end
    // Garbage above the tail must not matter
    do_msg({88'hdead_beef_cafe_f00d_1234_5, ct[3][39:0]}, 4'd5, 1'b1);
    lo5 = '0;
    lo5[39:0] = pt[3][39:0];
    chk("R8", "short recovered plaintext", last_out, lo5);

    // Load wins over associated data in the same cycle
    ctx = "R10";
    ad_valid = 1; ad_data = rnd128();
    init_valid = 1; init_key = rnd128(); init_nonce = rnd128();
    cycle();
    quiet();
    for (int i = 0; i < 10; i++) cycle();

    // Mixed sessions over the update rule, tails 1 and 15 included
    ctx = "R4";
    for (int s = 0; s < 6; s++) begin
      do_init(rnd128(), rnd128());
      for (int a = 0; a < s % 3; a++) do_ad(rnd128());
      for (int m = 0; m < 1 + s % 4; m++) do_msg(rnd128(), 4'd0, 1'($urandom % 2));
      do_msg(rnd128(), (s == 0) ? 4'd1 : (s == 1) ? 4'd15 : 4'($urandom % 16), 1'(s % 2));
      cycle();
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule